// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block owns the program counter and the stack pointer of a small processor core. It carries out control transfers: absolute jump, relative jump, absolute call, relative call and return. Each command arrives as one valid cycle carrying the command kind, a 16-bit absolute target and a 12-bit signed offset. Jumps finish in a single cycle. Calls and returns move the two-byte return address through a byte-wide memory port, one byte per cycle, on a stack that grows toward lower addresses.

A call records its return address and then writes it to the stack. An absolute call saves the address two past the current PC. A relative call saves the address one past it. A return reads the address back in the opposite order and reloads the PC from it. A relative target is the current PC plus the sign-extended offset plus one. All address arithmetic wraps at 16 bits. While the stack transfer is in progress, `busy` is high and commands are not accepted. Instruction fetch, decoding and interrupt entry belong to other blocks.

Top module: `callret_seq`

## Requirements
- R1: After a synchronous active-low reset, `pc_o` is 0x0000, `sp_o` is 0x0FFF, `busy` is low and neither `mem_we` nor `mem_re` is asserted.
- R2: A command is accepted on a rising edge where `cmd_valid` is high and `busy` is low. An accepted absolute jump (`cmd_op` = 1) loads `cmd_target` into `pc_o` at that edge. It leaves `sp_o` unchanged and makes no memory access.
- R3: An accepted relative jump (`cmd_op` = 2) loads `pc_o + sext(cmd_offset) + 1` at that edge. `cmd_offset` is a 12-bit two's complement value from -2048 to 2047. `sp_o` is unchanged.
- R4: An accepted absolute call (`cmd_op` = 3) pushes `pc_o + 2` and then loads `cmd_target` into `pc_o`.
- R5: An accepted relative call (`cmd_op` = 4) pushes `pc_o + 1` and then loads `pc_o + sext(cmd_offset) + 1`. The target is computed from the PC at acceptance.
- R6: A push takes the two cycles after acceptance. In the first, `mem_we` is high with the low return byte at address `sp_o`. In the second, it writes the high byte at the original `sp_o - 1`. `sp_o` drops by one after each write. At the end of the second cycle `pc_o` takes the target and `busy` falls. `mem_we` and `mem_re` are never high together.
- R7: An accepted return (`cmd_op` = 5) takes the two cycles after acceptance, with `mem_re` high in both. `mem_rdata` is valid in the same cycle. The first read is at `sp_o + 1` and supplies the high byte. `sp_o` then rises by one, and the second read at the new `sp_o + 1` supplies the low byte. At the end of the second cycle `pc_o` is `{high, low}` and `sp_o` is two above its value at acceptance.
- R8: While `busy` is high, `cmd_valid` is ignored: no command offered in those cycles changes `pc_o`, `sp_o` or the transfer in progress.
- R9: Command codes 0, 6 and 7 have no effect on `pc_o`, `sp_o`, `busy` or the memory port.
- R10: PC arithmetic wraps modulo 2^16. For example, a relative jump with offset 1 from 0xFFFF lands on 0x0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_op | input | 3 | Command kind: 1 jump, 2 relative jump, 3 call, 4 relative call, 5 return, others none |
| cmd_target | input | 16 | Absolute target for jump and call |
| cmd_offset | input | 12 | Signed offset for relative jump and call |
| pc_o | output | 16 | Current program counter |
| sp_o | output | 16 | Current stack pointer |
| busy | output | 1 | Stack transfer in progress, commands ignored |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe |
| mem_addr | output | 16 | Byte address for the stack access |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the cycle of `mem_re` |

## Verification
On every cycle the assertions check the following. Every stack strobe falls inside a busy window. Write and read are never high together. A write addresses the current stack pointer and is followed by a decrement. A read addresses one above it and is followed by an increment. A jump or a no-op code leaves the stack pointer alone. Other behaviour only the bench scenarios can show. This covers the byte order on the stack and the return values pushed for the two call kinds. It also covers the relative target at both ends of the offset range, wrap of the PC, a full call and return round trip, and commands held high across a busy window that must leave no trace.

// File: rtl/callret_pkg.sv
// Shared definitions for the call/return sequencer.
// Assumes command codes arrive on a 3-bit field; unlisted codes mean "no operation".
package callret_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_JMP   = 3'd1,
        OP_RJMP  = 3'd2,
        OP_CALL  = 3'd3,
        OP_RCALL = 3'd4,
        OP_RET   = 3'd5
    } cr_op_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_PUSH = 2'd1,
        SQ_POP  = 2'd2
    } cr_seq_e;

endpackage

// File: rtl/callret_target.sv
// Target and return-address arithmetic for control transfers.
// Assumes ADDR_W > OFS_W; all sums wrap at ADDR_W bits.
module callret_target
    import callret_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 12
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] abs_target,
    input  logic [OFS_W-1:0]  offset,
    output logic [ADDR_W-1:0] dest_pc,
    output logic [ADDR_W-1:0] ret_addr
);

    localparam int EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_ext;
    logic [ADDR_W-1:0] rel_pc;

    // Sign-extend the offset and form the relative destination.
    always_comb begin
        ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};
        rel_pc  = pc + ofs_ext + ADDR_W'(1);
    end

    // Pick the destination and the address to save for the command kind.
    always_comb begin
        case (op)
            OP_JMP, OP_CALL:   dest_pc = abs_target;
            OP_RJMP, OP_RCALL: dest_pc = rel_pc;
            default:           dest_pc = pc;
        endcase
        ret_addr = (op == OP_CALL) ? pc + ADDR_W'(2) : pc + ADDR_W'(1);
    end

endmodule

// File: rtl/callret_stack.sv
// Byte-serial stack engine: pushes a return address low byte first with
// post-decrement, and pops it high byte first with pre-increment.
// Assumes a memory whose read data is valid in the cycle of the read strobe.
module callret_stack
    import callret_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] SP_RESET = 16'h0FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_push,
    input  logic              start_pop,
    input  logic [ADDR_W-1:0] push_data,
    output logic              busy,
    output logic [ADDR_W-1:0] sp,
    output logic              push_done,
    output logic              pop_done,
    output logic [ADDR_W-1:0] pop_data,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    localparam int NBYTES = ADDR_W / 8;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    cr_seq_e           state;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] push_buf;
    logic [ADDR_W-9:0] pop_buf;
    logic [ADDR_W-1:0] pop_next;
    logic              last;

    // Decode the present step of the sequence.
    always_comb begin
        last      = (idx == LAST_IDX);
        busy      = (state != SQ_IDLE);
        mem_we    = (state == SQ_PUSH);
        mem_re    = (state == SQ_POP);
        mem_addr  = (state == SQ_POP) ? sp + ADDR_W'(1) : sp;
        mem_wdata = push_buf[7:0];
        pop_next  = {pop_buf, mem_rdata};
        pop_data  = pop_next;
        push_done = (state == SQ_PUSH) && last;
        pop_done  = (state == SQ_POP) && last;
    end

    // Advance the state, byte index, buffers and stack pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            idx      <= '0;
            push_buf <= '0;
            pop_buf  <= '0;
            sp       <= SP_RESET;
        end else begin
            case (state)
                SQ_IDLE: begin
                    idx <= '0;
                    if (start_push) begin
                        push_buf <= push_data;
                        state    <= SQ_PUSH;
                    end else if (start_pop) begin
                        state    <= SQ_POP;
                    end
                end
                SQ_PUSH: begin
                    sp       <= sp - ADDR_W'(1);
                    push_buf <= push_buf >> 8;
                    idx      <= idx + IDX_W'(1);
                    if (last) state <= SQ_IDLE;
                end
                SQ_POP: begin
                    sp      <= sp + ADDR_W'(1);
                    pop_buf <= pop_next[ADDR_W-9:0];
                    idx     <= idx + IDX_W'(1);
                    if (last) state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/callret_seq.sv
// Call/return sequencer top: holds the PC, accepts one command when idle,
// finishes jumps at once and hands calls and returns to the stack engine.
// Assumes ADDR_W is a multiple of 8 and commands are single-cycle pulses or held.
module callret_seq
    import callret_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 12,
    parameter logic [ADDR_W-1:0] PC_RESET = 16'h0000,
    parameter logic [ADDR_W-1:0] SP_RESET = 16'h0FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_target,
    input  logic [OFS_W-1:0]  cmd_offset,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic              busy,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    logic              accept;
    logic              is_jump;
    logic              is_call;
    logic              is_ret;
    logic [ADDR_W-1:0] dest_pc;
    logic [ADDR_W-1:0] ret_addr;
    logic [ADDR_W-1:0] pend_pc;
    logic              push_done;
    logic              pop_done;
    logic [ADDR_W-1:0] pop_data;

    // Classify the offered command and decide whether it is taken.
    always_comb begin
        accept  = cmd_valid && !busy;
        is_jump = (cmd_op == OP_JMP) || (cmd_op == OP_RJMP);
        is_call = (cmd_op == OP_CALL) || (cmd_op == OP_RCALL);
        is_ret  = (cmd_op == OP_RET);
    end

    callret_target #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) u_target (
        .pc         (pc_o),
        .op         (cmd_op),
        .abs_target (cmd_target),
        .offset     (cmd_offset),
        .dest_pc    (dest_pc),
        .ret_addr   (ret_addr)
    );

    callret_stack #(
        .ADDR_W   (ADDR_W),
        .SP_RESET (SP_RESET)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_push (accept && is_call),
        .start_pop  (accept && is_ret),
        .push_data  (ret_addr),
        .busy       (busy),
        .sp         (sp_o),
        .push_done  (push_done),
        .pop_done   (pop_done),
        .pop_data   (pop_data),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    // Hold the call destination until the push completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_pc <= '0;
        end else if (accept && is_call) begin
            pend_pc <= dest_pc;
        end
    end

    // Update the program counter from jumps, finished calls and finished returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o <= PC_RESET;
        end else if (accept && is_jump) begin
            pc_o <= dest_pc;
        end else if (push_done) begin
            pc_o <= pend_pc;
        end else if (pop_done) begin
            pc_o <= pop_data;
        end
    end

endmodule

// File: rtl/callret_seq_chk.sv
// Protocol checker for callret_seq, attached by bind below.
// Assumes reset is asserted from time zero.
module callret_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_target,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] sp_o,
    input logic              busy,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    // R6
    no_we_re_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R6
    push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == sp_o));

    // R6
    push_sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_o == ADDR_W'($past(sp_o) - ADDR_W'(1))));

    // R7
    pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (mem_addr == ADDR_W'(sp_o + ADDR_W'(1))));

    // R7
    pop_sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (sp_o == ADDR_W'($past(sp_o) + ADDR_W'(1))));

    // R2
    jump_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 3'd1) |=>
            (pc_o == $past(cmd_target) && $stable(sp_o) && !busy));

    // R9
    noop_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && (cmd_op == 3'd0 || cmd_op == 3'd6 || cmd_op == 3'd7)) |=>
            ($stable(pc_o) && $stable(sp_o) && !busy));

endmodule

bind callret_seq callret_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_target (cmd_target),
    .pc_o       (pc_o),
    .sp_o       (sp_o),
    .busy       (busy),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_addr   (mem_addr)
);

// File: tb/callret_seq_tb.sv
module callret_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_target = 16'h0;
    logic [11:0] cmd_offset = 12'h0;
    logic [15:0] pc_o, sp_o, mem_addr;
    logic        busy, mem_we, mem_re;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [7:0]  stk [65536];
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    callret_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_target(cmd_target), .cmd_offset(cmd_offset), .pc_o(pc_o), .sp_o(sp_o),
        .busy(busy), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = stk[mem_addr];

    always @(posedge clk) if (mem_we) stk[mem_addr] <= mem_wdata;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] tgt;
        logic [11:0] ofs;
        logic [15:0] pc;
        logic [15:0] sp;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{3'd1, 16'h1234, 12'h000, 16'h1234, 16'h0FFF},
        '{3'd2, 16'h0000, 12'h7FF, 16'h1A34, 16'h0FFF},
        '{3'd2, 16'h0000, 12'h800, 16'h1235, 16'h0FFF},
        '{3'd3, 16'h4000, 12'h000, 16'h4000, 16'h0FFD},
        '{3'd4, 16'h0000, 12'h005, 16'h4006, 16'h0FFB},
        '{3'd5, 16'h0000, 12'h000, 16'h4001, 16'h0FFD},
        '{3'd5, 16'h0000, 12'h000, 16'h1237, 16'h0FFF},
        '{3'd1, 16'hFFFF, 12'h000, 16'hFFFF, 16'h0FFF},
        '{3'd2, 16'h0000, 12'h001, 16'h0001, 16'h0FFF},
        '{3'd4, 16'h0000, 12'hFFF, 16'h0001, 16'h0FFD},
        '{3'd5, 16'h0000, 12'h000, 16'h0002, 16'h0FFF},
        '{3'd0, 16'h7777, 12'h123, 16'h0002, 16'h0FFF},
        '{3'd6, 16'h7777, 12'h123, 16'h0002, 16'h0FFF},
        '{3'd7, 16'h7777, 12'h123, 16'h0002, 16'h0FFF}
    };

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Offer one command for one cycle, then wait at negedges until idle.
    task automatic issue(input logic [2:0] op, input logic [15:0] tgt, input logic [11:0] ofs);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_target = tgt; cmd_offset = ofs;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "pc", pc_o, 16'h0000);
        chk("R1", "sp", sp_o, 16'h0FFF);
        chk("R1", "busy/we/re", {13'h0, busy, mem_we, mem_re}, 16'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i].op, VEC[i].tgt, VEC[i].ofs);
            chk(tag_of(VEC[i].op), $sformatf("vec%0d pc", i), pc_o, VEC[i].pc);
            chk(tag_of(VEC[i].op), $sformatf("vec%0d sp", i), sp_o, VEC[i].sp);
            if (i == 3) begin
                // R6 low byte of 0x1237 at the old SP, high byte below it
                chk("R6", "low byte at 0FFF", {8'h0, stk[16'h0FFF]}, 16'h0037);
                chk("R6", "high byte at 0FFE", {8'h0, stk[16'h0FFE]}, 16'h0012);
            end
            if (i == 8) chk("R10", "wrap pc", pc_o, 16'h0001);
        end

        // R6/R8 call with a jump held on cmd_valid throughout the busy window
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_target = 16'h2000; cmd_offset = 12'h0;
        @(negedge clk);
        cmd_op = 3'd1; cmd_target = 16'h5555;
        chk("R6", "busy 1st", {15'h0, busy}, 16'h1);
        chk("R6", "we/addr 1st", {mem_we, mem_addr[14:0]}, {1'b1, 15'h0FFF});
        chk("R4", "low byte pc+2", {8'h0, mem_wdata}, 16'h0004);
        @(negedge clk);
        chk("R6", "we/addr 2nd", {mem_we, mem_addr[14:0]}, {1'b1, 15'h0FFE});
        chk("R4", "high byte pc+2", {8'h0, mem_wdata}, 16'h0000);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R6", "busy done", {15'h0, busy}, 16'h0);
        chk("R8", "pc ignores held jump", pc_o, 16'h2000);
        chk("R8", "sp after call", sp_o, 16'h0FFD);

        // R7 pop order and addresses
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd5;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R7", "re/addr 1st", {mem_re, mem_addr[14:0]}, {1'b1, 15'h0FFE});
        @(negedge clk);
        chk("R7", "re/addr 2nd", {mem_re, mem_addr[14:0]}, {1'b1, 15'h0FFF});
        @(negedge clk);
        chk("R7", "pc after return", pc_o, 16'h0004);
        chk("R7", "sp after return", sp_o, 16'h0FFF);
        chk("R7", "idle after return", {15'h0, busy}, 16'h0);

        // R1 reset mid-transfer returns to the reset state
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_target = 16'h3000;
        @(negedge clk);
        cmd_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "pc after reset", pc_o, 16'h0000);
        chk("R1", "sp after reset", sp_o, 16'h0FFF);
        chk("R1", "busy after reset", {15'h0, busy}, 16'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule